// File: doc/BRIEF.md
# Flow-Through SEC-DED Data Path for a 16-Bit Memory Word

This block is a purely combinational error detection and correction path placed between a 16-bit user bus and a memory that stores eight check bits next to every data word. On the write side it derives the eight check bits from the outgoing user word. On the read side it recomputes those bits from the returned memory word and XORs them with the stored ones to form a syndrome. It then decodes the syndrome into a correctable or an uncorrectable event.

Two control inputs shape the read path. `short_mode` tells the block that only the lower six check bits were stored. The upper two stored bits are then ignored and the syndrome's upper two bits are held at zero. `correct_en` selects whether a located single data-bit error is repaired on the output or only reported. Both error flags are active low and behave the same in either correction setting.

Top module: `edac16_flowthrough`

## Requirements
- R1: `wr_check` bit i is the XOR of every `wr_data` bit d whose column has bit i set, inverted for i = 2, 3 and 7 (odd parity mask 8'h8C). The column table, with data bit 0 first, is 0B 0E 38 1A 0D 07 31 13 E5 D6 EC F2 D5 E9 EA F4 (hex). Check bit 0 therefore covers data bits 0, 4, 5, 6, 7, 8, 12 and 13, and check bit 3 covers data bits 0, 1, 2, 3, 4, 10, 13 and 14.
- R2: `rd_syndrome` equals `rd_check` XOR the check bits that R1 gives for `rd_data`. When `short_mode`=1, its bits 7:6 are 0.
- R3: A zero syndrome leaves both `cerr_n` and `uerr_n` high, and `out_data` equals `rd_data`.
- R4: With `correct_en`=1, a single flipped data bit d gives syndrome = column d (masked to bits 5:0 in short mode). `out_data` then equals the original word, `cerr_n`=0 and `uerr_n`=1.
- R5: A single flipped stored check bit gives a weight-1 syndrome. `cerr_n`=0, `uerr_n`=1, and `out_data` equals `rd_data`.
- R6: Any two flipped bits among data and used check bits give `uerr_n`=0 and `cerr_n`=1, and `out_data` equals `rd_data`. The two flags are never low together.
- R7: With `correct_en`=0, `out_data` always equals `rd_data`, and the flags match those that `correct_en`=1 would give.
- R8: With `short_mode`=1, stored check bits 7:6 have no effect on any output, and single errors are still located through bits 5:0 alone. With `short_mode`=0, a flipped stored bit 6 or 7 is reported as correctable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_data | input | 16 | User word being written |
| wr_check | output | 8 | Check bits to store with `wr_data` |
| rd_data | input | 16 | Data word read back from memory |
| rd_check | input | 8 | Check bits read back from memory |
| short_mode | input | 1 | 1: only check bits 5:0 are stored and used |
| correct_en | input | 1 | 1: repair single data-bit errors; 0: report only |
| rd_syndrome | output | 8 | Syndrome of the read word |
| out_data | output | 16 | Read word after optional correction |
| cerr_n | output | 1 | Low on a correctable error |
| uerr_n | output | 1 | Low on an uncorrectable error |

## Verification
The assertions hold continuously over whatever the bench drives. They check that the two flags are mutually exclusive, that a clean syndrome raises no flag, that report-only mode and uncorrectable events pass the data through untouched, that a repair flips exactly one bit, and that the upper syndrome bits stay zero in short mode. Whether the syndrome values and the located bit are the right ones can only be shown by the bench. Its sweeps inject every single data and check-bit error and a family of double errors into many words, in both check-word formats and both correction settings, and compare against check bits it computes independently.

// File: rtl/edac16_pkg.sv
package edac16_pkg;
  localparam int DATA_W  = 16;
  localparam int CHK_W   = 8;
  localparam int SHORT_W = 6;
  localparam logic [CHK_W-1:0] ODD_MASK  = 8'h8C;
  localparam logic [CHK_W-1:0] SHORT_KEEP = CHK_W'((1 << SHORT_W) - 1);

  // Syndrome column for each data bit: distinct, odd weight, and distinct in bits 5:0.
  function automatic logic [CHK_W-1:0] column(input int d);
    case (d)
      0: return 8'h0B;  1: return 8'h0E;  2: return 8'h38;  3: return 8'h1A;
      4: return 8'h0D;  5: return 8'h07;  6: return 8'h31;  7: return 8'h13;
      8: return 8'hE5;  9: return 8'hD6; 10: return 8'hEC; 11: return 8'hF2;
      12: return 8'hD5; 13: return 8'hE9; 14: return 8'hEA; 15: return 8'hF4;
      default: return '0;
    endcase
  endfunction

  // Data bits covered by one check bit (a row of the parity matrix).
  function automatic logic [DATA_W-1:0] row_mask(input int i);
    logic [DATA_W-1:0] m;
    logic [CHK_W-1:0]  c;
    m = '0;
    for (int d = 0; d < DATA_W; d++) begin
      c    = column(d);
      m[d] = c[i];
    end
    return m;
  endfunction
endpackage

// File: rtl/edac16_checkgen.sv
module edac16_checkgen
  import edac16_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  check
);
  for (genvar i = 0; i < CHK_W; i++) begin : g_row
    localparam logic [DATA_W-1:0] MASK = row_mask(i);
    assign check[i] = (^(data & MASK)) ^ ODD_MASK[i];
  end
endmodule

// File: rtl/edac16_syngen.sv
module edac16_syngen
  import edac16_pkg::*;
(
  input  logic [DATA_W-1:0] mem_data,
  input  logic [CHK_W-1:0]  mem_check,
  input  logic              short_mode,
  output logic [CHK_W-1:0]  syndrome
);
  logic [CHK_W-1:0] recomputed;
  logic [CHK_W-1:0] keep;

  edac16_checkgen u_regen (.data(mem_data), .check(recomputed));

  assign keep     = short_mode ? SHORT_KEEP : '1;
  assign syndrome = (mem_check ^ recomputed) & keep;

  always_comb begin
    // R2
    short_hi_zero_chk: assert (!short_mode || syndrome[CHK_W-1:SHORT_W] == '0);
  end
endmodule

// File: rtl/edac16_decoder.sv
module edac16_decoder
  import edac16_pkg::*;
(
  input  logic [CHK_W-1:0]  syndrome,
  input  logic              short_mode,
  input  logic              correct_en,
  input  logic [DATA_W-1:0] raw_data,
  output logic [DATA_W-1:0] data_out,
  output logic              cerr_n,
  output logic              uerr_n
);
  logic [DATA_W-1:0] hit_vec;
  logic              syn_zero;
  logic              syn_unit;
  logic              data_hit;
  logic              correctable;
  logic              uncorrectable;
  logic [CHK_W-1:0]  keep;

  assign keep = short_mode ? SHORT_KEEP : '1;

  for (genvar d = 0; d < DATA_W; d++) begin : g_col
    localparam logic [CHK_W-1:0] COL = column(d);
    assign hit_vec[d] = (syndrome == (COL & keep));
  end

  assign syn_zero      = (syndrome == '0);
  assign syn_unit      = $onehot(syndrome);
  assign data_hit      = |hit_vec;
  assign correctable   = syn_unit | data_hit;
  assign uncorrectable = !syn_zero && !correctable;

  assign data_out = correct_en ? (raw_data ^ hit_vec) : raw_data;
  assign cerr_n   = !correctable;
  assign uerr_n   = !uncorrectable;

  always_comb begin
    // R6
    flags_excl_chk: assert (cerr_n || uerr_n);
    // R3
    clean_noflag_chk: assert (!syn_zero || (cerr_n && uerr_n && data_out == raw_data));
    // R7
    detect_pass_chk: assert (correct_en || data_out == raw_data);
    // R6
    uncorr_pass_chk: assert (uerr_n || data_out == raw_data);
    // R4
    one_flip_chk: assert (!(correct_en && data_hit) || $countones(data_out ^ raw_data) == 1);
    // R4
    unique_hit_chk: assert ($onehot0(hit_vec));
  end
endmodule

// File: rtl/edac16_flowthrough.sv
module edac16_flowthrough
  import edac16_pkg::*;
(
  input  logic [15:0] wr_data,
  output logic [7:0]  wr_check,
  input  logic [15:0] rd_data,
  input  logic [7:0]  rd_check,
  input  logic        short_mode,
  input  logic        correct_en,
  output logic [7:0]  rd_syndrome,
  output logic [15:0] out_data,
  output logic        cerr_n,
  output logic        uerr_n
);
  edac16_checkgen u_wgen (.data(wr_data), .check(wr_check));

  edac16_syngen u_syn (
    .mem_data(rd_data), .mem_check(rd_check), .short_mode(short_mode),
    .syndrome(rd_syndrome)
  );

  edac16_decoder u_dec (
    .syndrome(rd_syndrome), .short_mode(short_mode), .correct_en(correct_en),
    .raw_data(rd_data), .data_out(out_data), .cerr_n(cerr_n), .uerr_n(uerr_n)
  );
endmodule

// File: tb/edac16_flowthrough_tb_top.sv
module edac16_flowthrough_tb_top;
  localparam int CLK_P = 10;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic [15:0] wr_data = '0, rd_data = '0, out_data;
  logic [7:0]  wr_check, rd_check = '0, rd_syndrome;
  logic        short_mode = 1'b0, correct_en = 1'b1, cerr_n, uerr_n;

  int n_checks = 0, n_fail = 0, cycles = 0;

  edac16_flowthrough dut_i (
    .wr_data(wr_data), .wr_check(wr_check), .rd_data(rd_data), .rd_check(rd_check),
    .short_mode(short_mode), .correct_en(correct_en), .rd_syndrome(rd_syndrome),
    .out_data(out_data), .cerr_n(cerr_n), .uerr_n(uerr_n)
  );

  function automatic logic [7:0] bcol(input int d);
    logic [7:0] t [16] = '{8'h0B, 8'h0E, 8'h38, 8'h1A, 8'h0D, 8'h07, 8'h31, 8'h13,
                           8'hE5, 8'hD6, 8'hEC, 8'hF2, 8'hD5, 8'hE9, 8'hEA, 8'hF4};
    return t[d];
  endfunction

  // Column-wise accumulation, then odd-parity inversion of bits 2, 3, 7.
  function automatic logic [7:0] bgen(input logic [15:0] w);
    logic [7:0] acc = 8'h00;
    for (int d = 0; d < 16; d++) if (w[d]) acc = acc ^ bcol(d);
    return acc ^ 8'h8C;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] w, input logic [15:0] rd, input logic [7:0] rc,
                       input logic sm, input logic ce);
    @(negedge clk);
    wr_data = w; rd_data = rd; rd_check = rc; short_mode = sm; correct_en = ce;
    @(posedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] w = 16'hACE1;
    logic [7:0]  keep, gc;
    // reset-state check: all-zero inputs give no flags
    drive(16'h0000, 16'h0000, bgen(16'h0000), 1'b0, 1'b1);
    chk("R3 reset clean flags", {cerr_n, uerr_n}, 2'b11);
    chk("R1 zero word check", wr_check, 8'h8C);

    for (int n = 0; n < 24; n++) begin
      if (n == 0) w = 16'hFFFF; else if (n == 1) w = 16'h0001;
      else w = {w[14:0], w[15] ^ w[13] ^ w[12] ^ w[10]};
      gc = bgen(w);
      for (int m = 0; m < 2; m++) begin
        keep = m[0] ? 8'h3F : 8'hFF;
        drive(w, w, gc, m[0], 1'b1);
        chk("R1 write check bits", wr_check, gc);
        chk("R3 clean syndrome", rd_syndrome, 8'h00);
        chk("R3 clean flags", {cerr_n, uerr_n}, 2'b11);
        chk("R3 clean data", out_data, w);
        for (int d = 0; d < 16; d++) begin
          drive(w, w ^ (16'h1 << d), gc, m[0], 1'b1);
          chk("R2 R4 single data syndrome", rd_syndrome, bcol(d) & keep);
          chk("R4 corrected data", out_data, w);
          chk("R4 flags", {cerr_n, uerr_n}, 2'b01);
          drive(w, w ^ (16'h1 << d), gc, m[0], 1'b0);
          chk("R7 detect passes data", out_data, w ^ (16'h1 << d));
          chk("R7 detect flags", {cerr_n, uerr_n}, 2'b01);
          drive(w, w ^ (16'h1 << d) ^ (16'h1 << ((d + 5) % 16)), gc, m[0], 1'b1);
          chk("R6 double data flags", {cerr_n, uerr_n}, 2'b10);
          chk("R6 double data passthrough", out_data, w ^ (16'h1 << d) ^ (16'h1 << ((d + 5) % 16)));
          drive(w, w ^ (16'h1 << d), gc ^ (8'h1 << (d % 6)), m[0], 1'b0);
          chk("R6 R7 data+check flags", {cerr_n, uerr_n}, 2'b10);
        end
        for (int k = 0; k < 8; k++) begin
          drive(w, w, gc ^ (8'h1 << k), m[0], 1'b1);
          if (m[0] && k >= 6) begin
            chk("R8 short ignores high bits flags", {cerr_n, uerr_n}, 2'b11);
            chk("R8 short syndrome", rd_syndrome, 8'h00);
          end else begin
            chk("R5 R8 check-bit syndrome", rd_syndrome, 8'h1 << k);
            chk("R5 check-bit flags", {cerr_n, uerr_n}, 2'b01);
            chk("R5 check-bit data", out_data, w);
          end
          drive(w, w, gc ^ (8'h1 << k) ^ (8'h1 << ((k + 1) % 6)), m[0], 1'b1);
          if (!(m[0] && k >= 6))
            chk("R6 double check flags", {cerr_n, uerr_n}, (k + 1) % 6 == k ? 2'b11 : 2'b10);
        end
        if (m[0]) begin
          drive(w, w ^ 16'h0100, gc ^ 8'hC0, 1'b1, 1'b1);
          chk("R8 short single with junk high bits", out_data, w);
          chk("R8 short junk flags", {cerr_n, uerr_n}, 2'b01);
        end
      end
    end
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule